// File: doc/BRIEF.md
# Rule-Table Frame Classifier

This block decides what happens to a received frame by walking a small programmable table of filter rules, one rule per clock cycle. An upstream parser presents a bank of 32-bit frame properties, indexed by a 4-bit property identifier, and pulses a start strobe. Each rule selects one property, masks it with a per-frame mask register, and compares the result with the rule's own compare word using one of four unsigned tests. The first decisive match ends the walk with either a reject verdict or an accept verdict naming a receive queue. A one-cycle done strobe reports the verdict.

Rules can be chained. A rule with its chain flag set does not decide on its own: when it matches, the walk carries on to the following rule; when it fails, the walk skips ahead either to the end of the chain or, if the rule also opens a group, to the rule that closes that group. Rules with property identifier 0 do not compare a property. They reload the mask register from their compare word and then match or fail by their compare operation. A plain register port writes and reads each rule's control word and compare word while the block is idle.

Top module: `frame_rule_walker`

## Requirements
- R1: The control word places the property identifier in bits 31:28, the compare operation in bits 26:25, the chain flag in bit 24, the reject flag in bit 23, the group flag in bit 22 and the queue index in bits 5:0; every other bit, bit 27 included, reads back as zero. Port select 0 addresses the control word and select 1 the compare word; a write is visible on the read data in the cycle after it.
- R2: At the start of every frame the mask register holds all ones. A rule with property identifier 0 loads the mask with its compare word whether it matches or not, and it matches for operation 00 or 01 and fails for 10 or 11.
- R3: A rule with a nonzero property identifier compares (property AND mask) against its compare word as unsigned values: operation 00 equal, 01 greater-or-equal, 10 not-equal, 11 less-than. The property inputs are never altered.
- R4: A matching rule with the chain flag clear ends the walk: reject when its reject flag is 1, otherwise accept to its queue index. The done strobe rises k+1 clock edges after the edge that takes the start strobe, where k is the index of the deciding rule, and busy falls on that same edge.
- R5: A rule with the chain flag set never decides, whatever its reject flag. If it matches, the next rule is evaluated normally; if it fails and its group flag is clear, rules are skipped up to and including the next rule whose chain flag is clear.
- R6: A chained rule with the group flag set that fails makes the walk skip up to and including the next rule whose group flag is set; skipped rules neither decide nor touch the mask. When it matches, the following rules are evaluated normally, and the closing rule (group flag set, chain flag clear) decides like any other rule.
- R7: When the last table rule is passed with no decisive match, the verdict is accept to queue 0 and done rises 16 edges after the start edge.
- R8: While busy, table writes and start strobes have no effect.
- R9: Done lasts exactly one cycle; busy is high from the edge after an accepted start until the done edge, and low after reset.
- R10: The mask loaded during one frame does not carry into the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin classifying the current properties |
| props_i | input | 512 | 16 properties of 32 bits, property p at bits p*32 upward |
| cfg_we_i | input | 1 | Table write enable |
| cfg_sel_i | input | 1 | 0 control word, 1 compare word |
| cfg_idx_i | input | 4 | Table rule index for read and write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for the addressed word |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle verdict strobe |
| reject_o | output | 1 | Verdict: frame rejected |
| queue_o | output | 6 | Verdict: accepting queue index |

## Verification
The only timed result is the verdict: for a frame decided at rule k, done, the falling busy and the reject and queue outputs are due exactly k+1 edges after the edge that takes start, with a default verdict due after 16 edges. The bench runs a behavioural walk of its own table copy to obtain k and the verdict, then samples on every falling clock edge and checks busy and done against that count in each cycle, including the cycle after done. Read data is combinational and checked just after the inputs settle, one cycle after the write edge.

// File: rtl/frw_pkg.sv
package frw_pkg;

   // Control word field positions (decoded by the walker)
   localparam int PID_LSB   = 28;
   localparam int PID_W     = 4;
   localparam int OP_LSB    = 25;
   localparam int CHAIN_BIT = 24;
   localparam int REJ_BIT   = 23;
   localparam int GROUP_BIT = 22;
   localparam int CTRL_W    = 32;
   localparam int NUM_PROPS = 1 << PID_W;

   typedef enum logic [1:0] {
      OP_EQ = 2'b00,
      OP_GE = 2'b01,
      OP_NE = 2'b10,
      OP_LT = 2'b11
   } cmp_op_e;

   typedef enum logic [1:0] {
      SK_NONE  = 2'd0,
      SK_CHAIN = 2'd1,
      SK_GROUP = 2'd2
   } skip_e;

   function automatic logic [CTRL_W-1:0] ctrl_keep_mask(input int queue_w);
      logic [CTRL_W-1:0] m;
      m = '0;
      for (int b = 0; b < CTRL_W; b++) begin
         if (b < queue_w) m[b] = 1'b1;
         if (b >= GROUP_BIT && b <= OP_LSB + 1) m[b] = 1'b1;
         if (b >= PID_LSB) m[b] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/frw_rule_store.sv
module frw_rule_store
   import frw_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int DATA_W  = 32,
   parameter int QUEUE_W = 6,
   parameter int IDX_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               busy_i,
   input  logic               wr_en_i,
   input  logic               sel_i,
   input  logic [IDX_W-1:0]   idx_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  rdata_o,
   input  logic [IDX_W-1:0]   walk_idx_i,
   output logic [CTRL_W-1:0]  walk_ctrl_o,
   output logic [DATA_W-1:0]  walk_word_o
);

   localparam logic [CTRL_W-1:0] KEEP = ctrl_keep_mask(QUEUE_W);

   logic [ENTRIES-1:0][CTRL_W-1:0] ctrl_q;
   logic [ENTRIES-1:0][DATA_W-1:0] word_q;
   logic [ENTRIES-1:0]             hit;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_hit
      assign hit[i] = wr_en_i && !busy_i && (idx_i == IDX_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         word_q <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (hit[i] && !sel_i) ctrl_q[i] <= wdata_i[CTRL_W-1:0] & KEEP;
            if (hit[i] &&  sel_i) word_q[i] <= wdata_i;
         end
      end
   end

   assign rdata_o     = sel_i ? word_q[idx_i] : DATA_W'(ctrl_q[idx_i]);
   assign walk_ctrl_o = ctrl_q[walk_idx_i];
   assign walk_word_o = word_q[walk_idx_i];

   logic unused_wdata;
   if (DATA_W > CTRL_W) begin : g_wide
      assign unused_wdata = ^wdata_i[DATA_W-1:CTRL_W];
   end else begin : g_exact
      assign unused_wdata = 1'b0;
   end

   // R8: the table cannot change while a walk is running
   assert_table_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && busy_i) |=> ($stable(ctrl_q) && $stable(word_q)))
      else $error("table written while busy");

endmodule

// File: rtl/frw_rule_eval.sv
module frw_rule_eval
   import frw_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int QUEUE_W = 6
) (
   input  logic [CTRL_W-1:0]           ctrl_i,
   input  logic [DATA_W-1:0]           word_i,
   input  logic [DATA_W-1:0]           mask_i,
   input  logic [NUM_PROPS*DATA_W-1:0] props_i,
   output logic                        match_o,
   output logic                        load_mask_o,
   output logic                        chain_o,
   output logic                        rej_o,
   output logic                        group_o,
   output logic [QUEUE_W-1:0]          queue_o
);

   logic [DATA_W-1:0] prop_arr [NUM_PROPS];
   logic [PID_W-1:0]  pid;
   cmp_op_e           op;
   logic [DATA_W-1:0] masked;

   for (genvar p = 0; p < NUM_PROPS; p++) begin : g_prop
      assign prop_arr[p] = props_i[p*DATA_W +: DATA_W];
   end

   assign pid         = ctrl_i[PID_LSB +: PID_W];
   assign op          = cmp_op_e'(ctrl_i[OP_LSB +: 2]);
   assign chain_o     = ctrl_i[CHAIN_BIT];
   assign rej_o       = ctrl_i[REJ_BIT];
   assign group_o     = ctrl_i[GROUP_BIT];
   assign queue_o     = ctrl_i[QUEUE_W-1:0];
   assign load_mask_o = (pid == '0);
   assign masked      = prop_arr[pid] & mask_i;

   always_comb begin
      if (pid == '0) begin
         match_o = !op[1];
      end else begin
         unique case (op)
            OP_EQ:   match_o = (masked == word_i);
            OP_GE:   match_o = (masked >= word_i);
            OP_NE:   match_o = (masked != word_i);
            default: match_o = (masked <  word_i);
         endcase
      end
   end

   logic unused_ctrl;
   assign unused_ctrl = ^{ctrl_i[OP_LSB+2], ctrl_i[GROUP_BIT-1:QUEUE_W]};

endmodule

// File: rtl/frw_walker_fsm.sv
module frw_walker_fsm
   import frw_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int DATA_W  = 32,
   parameter int QUEUE_W = 6,
   parameter int IDX_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               match_i,
   input  logic               load_mask_i,
   input  logic               chain_i,
   input  logic               rej_i,
   input  logic               group_i,
   input  logic [QUEUE_W-1:0] queue_i,
   input  logic [DATA_W-1:0]  word_i,
   output logic [IDX_W-1:0]   idx_o,
   output logic [DATA_W-1:0]  mask_o,
   output logic               busy_o,
   output logic               done_o,
   output logic               reject_o,
   output logic [QUEUE_W-1:0] queue_o
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic               busy_q, done_q, rej_q;
   logic [IDX_W-1:0]   idx_q;
   logic [DATA_W-1:0]  mask_q, mask_n;
   logic [QUEUE_W-1:0] queue_q;
   skip_e              skip_q, skip_n;
   logic               decide, last;

   assign last = (idx_q == LAST);

   always_comb begin
      skip_n = skip_q;
      mask_n = mask_q;
      decide = 1'b0;
      unique case (skip_q)
         SK_CHAIN: if (!chain_i) skip_n = SK_NONE;
         SK_GROUP: if (group_i)  skip_n = SK_NONE;
         default: begin
            if (load_mask_i) mask_n = word_i;
            if (match_i) begin
               decide = !chain_i;
            end else if (chain_i) begin
               skip_n = group_i ? SK_GROUP : SK_CHAIN;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         rej_q   <= 1'b0;
         queue_q <= '0;
         idx_q   <= '0;
         mask_q  <= '1;
         skip_q  <= SK_NONE;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q <= 1'b1;
               idx_q  <= '0;
               mask_q <= '1;
               skip_q <= SK_NONE;
            end
         end else begin
            skip_q <= skip_n;
            mask_q <= mask_n;
            if (decide || last) begin
               busy_q  <= 1'b0;
               done_q  <= 1'b1;
               rej_q   <= decide && rej_i;
               queue_q <= (decide && !rej_i) ? queue_i : '0;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign idx_o    = idx_q;
   assign mask_o   = mask_q;
   assign busy_o   = busy_q;
   assign done_o   = done_q;
   assign reject_o = rej_q;
   assign queue_o  = queue_q;

   // R9: verdict strobe is a single cycle
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q) else $error("done longer than one cycle");

   // R9: an accepted start makes the block busy
   assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_q) |=> busy_q) else $error("start not taken");

   // R2, R10: every frame begins with an all-ones mask
   assert_mask_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_q) |=> (mask_q == {DATA_W{1'b1}})) else $error("mask not reset");

   // R4: busy is low whenever the verdict is presented
   assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q) else $error("busy during done");

   // R6: a group skip runs until a rule with the group flag
   assert_group_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && skip_q == SK_GROUP && !group_i && !last) |=> (skip_q == SK_GROUP && !done_q))
      else $error("group skip left early");

endmodule

// File: rtl/frame_rule_walker.sv
module frame_rule_walker
   import frw_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int DATA_W  = 32,
   parameter int QUEUE_W = 6,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic [NUM_PROPS*DATA_W-1:0] props_i,
   input  logic                        cfg_we_i,
   input  logic                        cfg_sel_i,
   input  logic [IDX_W-1:0]            cfg_idx_i,
   input  logic [DATA_W-1:0]           cfg_wdata_i,
   output logic [DATA_W-1:0]           cfg_rdata_o,
   output logic                        busy_o,
   output logic                        done_o,
   output logic                        reject_o,
   output logic [QUEUE_W-1:0]          queue_o
);

   if (ENTRIES < 2 || ENTRIES > 256) begin : g_bad_entries
      $error("ENTRIES out of range");
   end
   if (DATA_W < CTRL_W) begin : g_bad_width
      $error("DATA_W must hold a control word");
   end
   if (QUEUE_W < 1 || QUEUE_W > GROUP_BIT) begin : g_bad_queue
      $error("QUEUE_W overlaps control fields");
   end

   logic [IDX_W-1:0]   walk_idx;
   logic [CTRL_W-1:0]  walk_ctrl;
   logic [DATA_W-1:0]  walk_word, mask;
   logic               match, load_mask, chain, rej, group;
   logic [QUEUE_W-1:0] rule_queue;

   frw_rule_store #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .QUEUE_W(QUEUE_W), .IDX_W(IDX_W)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .busy_i      (busy_o),
      .wr_en_i     (cfg_we_i),
      .sel_i       (cfg_sel_i),
      .idx_i       (cfg_idx_i),
      .wdata_i     (cfg_wdata_i),
      .rdata_o     (cfg_rdata_o),
      .walk_idx_i  (walk_idx),
      .walk_ctrl_o (walk_ctrl),
      .walk_word_o (walk_word)
   );

   frw_rule_eval #(.DATA_W(DATA_W), .QUEUE_W(QUEUE_W)) u_eval (
      .ctrl_i      (walk_ctrl),
      .word_i      (walk_word),
      .mask_i      (mask),
      .props_i     (props_i),
      .match_o     (match),
      .load_mask_o (load_mask),
      .chain_o     (chain),
      .rej_o       (rej),
      .group_o     (group),
      .queue_o     (rule_queue)
   );

   frw_walker_fsm #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .QUEUE_W(QUEUE_W), .IDX_W(IDX_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .match_i     (match),
      .load_mask_i (load_mask),
      .chain_i     (chain),
      .rej_i       (rej),
      .group_i     (group),
      .queue_i     (rule_queue),
      .word_i      (walk_word),
      .idx_o       (walk_idx),
      .mask_o      (mask),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .reject_o    (reject_o),
      .queue_o     (queue_o)
   );

endmodule

// File: tb/test_frame_rule_walker.sv
module test_frame_rule_walker;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [511:0] props_flat;
   logic         cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [3:0]   cfg_idx = '0;
   logic [31:0]  cfg_wdata = '0;
   logic [31:0]  cfg_rdata;
   logic         busy, done, reject;
   logic [5:0]   queue;

   int checks = 0;
   int fails  = 0;

   logic [31:0] m_ctrl [16];
   logic [31:0] m_word [16];
   logic [31:0] props  [16];

   localparam logic [31:0] KEEP   = 32'hF7C0_003F;
   localparam logic [31:0] FILLER_WORD = 32'hDEAD_BEEF;

   always #5 clk = ~clk;

   always_comb
      for (int p = 0; p < 16; p++) props_flat[p*32 +: 32] = props[p];

   frame_rule_walker i_frame_rule_walker (
      .clk(clk), .rst_n(rst_n), .start_i(start), .props_i(props_flat),
      .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_idx_i(cfg_idx),
      .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .busy_o(busy),
      .done_o(done), .reject_o(reject), .queue_o(queue)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int pid, input int op, input bit ch,
                                      input bit rj, input bit grp, input int q);
      return {pid[3:0], 1'b0, op[1:0], ch, rj, grp, 16'h0, q[5:0]};
   endfunction

   // behavioural walk of the bench's own table copy
   task automatic model(output int k, output bit rj, output int q);
      logic [31:0] mask = 32'hFFFF_FFFF;
      int skip = 0;
      k = 15; rj = 0; q = 0;
      for (int i = 0; i < 16; i++) begin
         int pid = int'(m_ctrl[i][31:28]);
         int op  = int'(m_ctrl[i][26:25]);
         bit ch  = m_ctrl[i][24];
         bit grp = m_ctrl[i][22];
         bit hit;
         logic [31:0] v;
         if (skip == 1) begin if (!ch) skip = 0; continue; end
         if (skip == 2) begin if (grp) skip = 0; continue; end
         if (pid == 0) begin
            mask = m_word[i];
            hit = (op < 2);
         end else begin
            v = props[pid] & mask;
            case (op)
               0: hit = (v == m_word[i]);
               1: hit = (v >= m_word[i]);
               2: hit = (v != m_word[i]);
               default: hit = (v < m_word[i]);
            endcase
         end
         if (hit) begin
            if (!ch) begin
               k = i; rj = m_ctrl[i][23];
               q = rj ? 0 : int'(m_ctrl[i][5:0]);
               return;
            end
         end else if (ch) begin
            skip = grp ? 2 : 1;
         end
      end
   endtask

   task automatic wr(input int idx, input bit sel, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx[3:0]; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel) m_word[idx] = data; else m_ctrl[idx] = data & KEEP;
   endtask

   task automatic rd_chk(input string req, input int idx, input bit sel, input logic [31:0] exp);
      @(negedge clk);
      cfg_sel = sel; cfg_idx = idx[3:0];
      #1 chk(req, cfg_rdata, exp);
   endtask

   task automatic fill_default();
      for (int i = 0; i < 16; i++) begin
         wr(i, 0, mk(15, 0, 0, 0, 0, 0));
         wr(i, 1, FILLER_WORD);
      end
   endtask

   task automatic run_frame(input string req, input bit poke);
      int k, q;
      bit rj;
      model(k, rj, q);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk({req, "/R9 busy after start"}, 32'(busy), 32'd1);
      chk({req, "/R9 no early done"}, 32'(done), 32'd0);
      for (int j = 0; j <= k; j++) begin
         if (poke && j == 0) begin
            cfg_we = 1'b1; cfg_sel = 1'b0; cfg_idx = 4'd5; cfg_wdata = 32'hFFFF_FFFF;
            start = 1'b1;
         end
         @(negedge clk);
         cfg_we = 1'b0;
         start = 1'b0;
         chk({req, "/R4 done timing"}, 32'(done), 32'(j == k));
         chk({req, "/R9 busy timing"}, 32'(busy), 32'(j < k));
         if (j == k) begin
            chk({req, "/R4 reject verdict"}, 32'(reject), 32'(rj));
            chk({req, "/R4 queue verdict"}, 32'(queue), 32'(q));
         end
      end
      @(negedge clk);
      chk({req, "/R9 done single"}, 32'(done), 32'd0);
      chk({req, "/R9 idle after"}, 32'(busy), 32'd0);
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         m_ctrl[i] = '0; m_word[i] = '0; props[i] = '0;
      end
      props[2] = 32'h1234_5678;
      props[3] = 32'h9000_0000;
      props[4] = 32'h1234_5678;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state (R9, R1)
      chk("R9 reset busy", 32'(busy), 32'd0);
      chk("R9 reset done", 32'(done), 32'd0);
      rd_chk("R1 reset ctrl", 0, 0, 32'h0);

      // R1: field layout and reserved bits
      wr(3, 0, 32'hFFFF_FFFF);
      rd_chk("R1 ctrl readback", 3, 0, 32'hF7C0_003F);
      wr(3, 1, 32'hA5A5_0F0F);
      rd_chk("R1 word readback", 3, 1, 32'hA5A5_0F0F);

      // R3/R4: equal match accepts to queue 5
      fill_default();
      wr(1, 0, mk(2, 0, 0, 0, 0, 5)); wr(1, 1, 32'h1234_5678);
      run_frame("R3 eq accept", 0);

      // R3: unsigned less-than fails, greater-or-equal rejects
      wr(0, 0, mk(3, 3, 0, 0, 0, 1)); wr(0, 1, 32'h8000_0000);
      wr(1, 0, mk(3, 1, 0, 1, 0, 2)); wr(1, 1, 32'h9000_0000);
      run_frame("R3 ge reject", 0);
      wr(1, 0, mk(3, 2, 0, 0, 0, 2));
      wr(2, 0, mk(3, 3, 0, 0, 0, 7)); wr(2, 1, 32'hA000_0000);
      run_frame("R3 ne lt", 0);
      chk("R3 props untouched", props_flat[3*32 +: 32], 32'h9000_0000);

      // R2/R5: mask load via pid 0, chained rule ignores reject flag
      fill_default();
      wr(0, 0, mk(0, 1, 1, 1, 0, 0)); wr(0, 1, 32'h0000_FFFF);
      wr(1, 0, mk(4, 0, 0, 0, 0, 9)); wr(1, 1, 32'h0000_5678);
      run_frame("R2 mask chain", 0);

      // R10/R7: no mask carried over, default verdict at end
      wr(0, 0, mk(4, 0, 0, 0, 0, 8)); wr(0, 1, 32'h0000_5678);
      wr(1, 0, mk(15, 0, 0, 0, 0, 0)); wr(1, 1, FILLER_WORD);
      run_frame("R10 R7 default", 0);

      // R2: pid 0 with failing op still loads the mask
      fill_default();
      wr(0, 0, mk(0, 2, 0, 0, 0, 3)); wr(0, 1, 32'h0);
      wr(1, 0, mk(4, 0, 0, 0, 0, 2)); wr(1, 1, 32'h0);
      run_frame("R2 fail loads mask", 0);

      // R5: failed chain skips through next unchained rule
      fill_default();
      wr(0, 0, mk(2, 2, 1, 0, 0, 0)); wr(0, 1, 32'h1234_5678);
      wr(1, 0, mk(2, 0, 1, 0, 0, 0)); wr(1, 1, 32'h1234_5678);
      wr(2, 0, mk(2, 0, 0, 0, 0, 3)); wr(2, 1, 32'h1234_5678);
      wr(3, 0, mk(2, 0, 0, 0, 0, 4)); wr(3, 1, 32'h1234_5678);
      run_frame("R5 chain skip", 0);

      // R6: failed group opener skips to closing rule; skipped pid 0 inert
      fill_default();
      wr(0, 0, mk(2, 2, 1, 0, 1, 0)); wr(0, 1, 32'h1234_5678);
      wr(1, 0, mk(0, 0, 0, 0, 0, 1)); wr(1, 1, 32'h0);
      wr(2, 0, mk(2, 0, 0, 0, 1, 6)); wr(2, 1, 32'h1234_5678);
      wr(3, 0, mk(2, 0, 0, 0, 0, 11)); wr(3, 1, 32'h1234_5678);
      run_frame("R6 group skip", 0);

      // R6: matching group opener, closing rule rejects
      fill_default();
      wr(0, 0, mk(2, 0, 1, 0, 1, 0)); wr(0, 1, 32'h1234_5678);
      wr(1, 0, mk(3, 0, 0, 0, 0, 1)); wr(1, 1, 32'h0000_0001);
      wr(2, 0, mk(2, 0, 0, 1, 1, 6)); wr(2, 1, 32'h1234_5678);
      run_frame("R6 group enter", 0);

      // R8: write and start during a walk are ignored
      fill_default();
      run_frame("R8 busy poke", 1);
      rd_chk("R8 write ignored", 5, 0, mk(15, 0, 0, 0, 0, 0));

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule